// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces an active-low system reset from two conditions: a supply-good flag and a software watchdog. While the supply is bad the reset is held. When the supply comes good, the reset is held for a fixed hold interval and then released. All timing is counted in pulses of a slow tick input, one pulse per millisecond, so the default hold of 200 ticks gives 200 ms and the default window of 1600 ticks gives 1.6 s.

After release, and while the watchdog is enabled, the block times the kick input. Any level change on kick, in either direction, restarts the window. If a full window passes without a kick, reset is pulsed for one hold interval and a fresh window follows. This repeats until a kick arrives, the supply fails, or the watchdog is disabled. With the watchdog disabled, the reset follows only the supply flag and the hold delay.

All three inputs pass through a multi-flop synchronizer before any logic sees them.

Top module: `supv_reset_wdog`

## Requirements
- R1: While arst_n is low, sys_rst_n is 0.
- R2: While the synchronized pwr_ok is low, sys_rst_n is 0 whatever tick, kick and wd_en do.
- R3: After pwr_ok rises, sys_rst_n stays 0 through the first HOLD_TICKS-1 tick pulses and becomes 1 on the HOLD_TICKS-th tick pulse. A release only happens on a cycle with tick high.
- R4: With wd_en low, a released sys_rst_n stays 1 for any number of ticks.
- R5: With wd_en high and no kick edge, sys_rst_n returns to 0 on the WIN_TICKS-th tick pulse after release.
- R6: A rising or falling edge on kick while released restarts the window, so expiry falls on the WIN_TICKS-th tick after the edge.
- R7: After an expiry, sys_rst_n is 0 for HOLD_TICKS ticks and then 1 for a WIN_TICKS window, and this pulse-and-window cycle repeats.
- R8: Kick edges while sys_rst_n is 0 are ignored. Every window starts fresh at release.
- R9: pwr_ok falling during a reset pulse cancels that pulse. After pwr_ok recovers, a full HOLD_TICKS hold applies.
- R10: A kick edge that reaches the core in the same cycle as the tick that would end the window wins: the window restarts and no reset occurs.
- R11: A pwr_ok fall that reaches the core in the same cycle as the final hold tick wins: the reset stays asserted.
- R12: Clearing wd_en during a reset pulse lets that pulse finish. No further pulses follow.
- R13: Every input passes through SYNC_STAGES flops. A fall of pwr_ok shows at sys_rst_n on the (SYNC_STAGES+1)-th rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset of the block |
| tick | input | 1 | One-cycle pulse per timebase unit (nominally 1 ms) |
| pwr_ok | input | 1 | Supply-good flag, asynchronous |
| kick | input | 1 | Watchdog service input; either edge counts as a kick, asynchronous |
| wd_en | input | 1 | Watchdog enable, asynchronous |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
Two pairs of events can land in the same cycle. A kick edge can coincide with the tick that would end the window. A supply drop can coincide with the tick that would end the hold. The bench provokes each pair by changing the input exactly SYNC_STAGES cycles before raising tick, so the synchronized edge and the tick reach the state machine together. It then judges the outcome on the next falling clock edge: the kick must keep the reset released for a whole new window, and the supply drop must keep the reset asserted for a whole new hold. A sweep that places a kick after every possible tick count in the window confirms that the restart works at each position.

// File: rtl/supv_pkg.sv
package supv_pkg;

   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_HOLD = 2'd1,
      ST_RUN  = 2'd2
   } supv_state_e;

   function automatic int unsigned supv_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain[0] <= '0;
      else         chain[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) chain[s] <= '0;
         else         chain[s] <= chain[s-1];
      end
   end

   assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/supv_edge.sv
module supv_edge #(
   parameter bit BOTH_EDGES = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic sig,
   output logic pulse
);

   logic sig_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) sig_q <= 1'b0;
      else         sig_q <= sig;
   end

   if (BOTH_EDGES) begin : g_any
      assign pulse = sig ^ sig_q;
   end else begin : g_rise
      assign pulse = sig & ~sig_q;
   end

endmodule

// File: rtl/supv_tick_cnt.sv
module supv_tick_cnt #(
   parameter int unsigned WIDTH = 11
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [WIDTH-1:0] cnt
);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)  cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   // R7: the phase limits are always below the counter range, so it never wraps
   p_no_wrap_r7: assert property (@(posedge clk) disable iff (!arst_n)
      (inc && !clr) |-> (cnt != '1));

endmodule

// File: rtl/supv_reset_wdog.sv
module supv_reset_wdog #(
   parameter int unsigned HOLD_TICKS  = 200,
   parameter int unsigned WIN_TICKS   = 1600,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          KICK_BOTH   = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic tick,
   input  logic pwr_ok,
   input  logic kick,
   input  logic wd_en,
   output logic sys_rst_n
);
   import supv_pkg::*;

   localparam int unsigned MAXT = supv_max(HOLD_TICKS, WIN_TICKS);
   localparam int unsigned CW   = $clog2(MAXT + 1);

   if (HOLD_TICKS < 1) begin : g_bad_hold
      $error("HOLD_TICKS must be at least 1");
   end
   if (WIN_TICKS < 2) begin : g_bad_win
      $error("WIN_TICKS must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [2:0]  raw_in, syn_in;
   logic        pwr_s, kick_s, wd_s, kick_edge;
   logic        cnt_clr, cnt_inc;
   logic [CW-1:0] cnt;
   supv_state_e state, state_nx;

   assign raw_in = {wd_en, kick, pwr_ok};

   supv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .arst_n(arst_n), .d_async(raw_in), .d_sync(syn_in)
   );

   assign pwr_s  = syn_in[0];
   assign kick_s = syn_in[1];
   assign wd_s   = syn_in[2];

   supv_edge #(.BOTH_EDGES(KICK_BOTH)) u_kick_edge (
      .clk(clk), .arst_n(arst_n), .sig(kick_s), .pulse(kick_edge)
   );

   supv_tick_cnt #(.WIDTH(CW)) u_cnt (
      .clk(clk), .arst_n(arst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
   );

   logic hold_last, win_last;
   assign hold_last = (cnt == CW'(HOLD_TICKS - 1));
   assign win_last  = (cnt == CW'(WIN_TICKS - 1));

   always_comb begin
      state_nx = state;
      cnt_clr  = 1'b0;
      cnt_inc  = 1'b0;
      if (!pwr_s) begin
         state_nx = ST_OFF;
         cnt_clr  = 1'b1;
      end else begin
         unique case (state)
            ST_OFF: begin
               state_nx = ST_HOLD;
               cnt_clr  = 1'b1;
            end
            ST_HOLD: begin
               if (tick) begin
                  if (hold_last) begin
                     state_nx = ST_RUN;
                     cnt_clr  = 1'b1;
                  end else begin
                     cnt_inc = 1'b1;
                  end
               end
            end
            ST_RUN: begin
               if (!wd_s || kick_edge) begin
                  cnt_clr = 1'b1;
               end else if (tick) begin
                  if (win_last) begin
                     state_nx = ST_HOLD;
                     cnt_clr  = 1'b1;
                  end else begin
                     cnt_inc = 1'b1;
                  end
               end
            end
            default: begin
               state_nx = ST_OFF;
               cnt_clr  = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) state <= ST_OFF;
      else         state <= state_nx;
   end

   assign sys_rst_n = (state == ST_RUN);

   // R2: a low synchronized supply forces reset on the next cycle
   p_pwr_low_r2: assert property (@(posedge clk) disable iff (!arst_n)
      !pwr_s |=> !sys_rst_n);

   // R3: a release only follows a tick pulse
   p_release_on_tick_r3: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(sys_rst_n) |-> $past(tick));

   // R4: with the watchdog off, a released output stays released while supply holds
   p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!arst_n)
      (sys_rst_n && !wd_s && pwr_s) |=> sys_rst_n);

   // R6: a kick edge while released keeps reset released and restarts the count
   p_kick_restart_r6: assert property (@(posedge clk) disable iff (!arst_n)
      (sys_rst_n && pwr_s && wd_s && kick_edge) |=> (sys_rst_n && cnt == '0));

endmodule

// File: tb/supv_reset_wdog_tb.sv
module supv_reset_wdog_tb;

   localparam int unsigned HOLD = 4;
   localparam int unsigned WIN  = 10;
   localparam int unsigned SYNC = 2;

   logic clk = 1'b0;
   logic arst_n, tick, pwr_ok, kick, wd_en, sys_rst_n;
   int   n_checks = 0;
   int   n_errors = 0;

   always #2.5 clk = ~clk;

   supv_reset_wdog #(.HOLD_TICKS(HOLD), .WIN_TICKS(WIN), .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .arst_n(arst_n), .tick(tick), .pwr_ok(pwr_ok),
      .kick(kick), .wd_en(wd_en), .sys_rst_n(sys_rst_n)
   );

   task automatic chk(input logic expv, input string tag);
      n_checks++;
      if (sys_rst_n !== expv) begin
         n_errors++;
         $display("FAIL %s: sys_rst_n=%b expected %b at %0t", tag, sys_rst_n, expv, $time);
      end
   endtask

   // idle long enough for any input change to clear the synchronizer, then one tick
   task automatic step();
      repeat (4) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   // raise tick so it reaches the core in the same cycle as a change made just before
   task automatic tick_aligned();
      repeat (SYNC) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic run_hold(input string tag);
      for (int i = 1; i <= HOLD; i++) begin
         step();
         chk(i == HOLD, tag);
      end
   endtask

   task automatic run_window(input string tag);
      for (int i = 1; i <= WIN; i++) begin
         step();
         chk(i < WIN, tag);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      arst_n = 1'b0; tick = 1'b0; pwr_ok = 1'b0; kick = 1'b0; wd_en = 1'b0;
      repeat (3) @(negedge clk);
      chk(1'b0, "R1");
      arst_n = 1'b1;

      // R2: supply low, ticks and kicks do nothing
      for (int i = 0; i < 6; i++) begin
         kick  = ~kick;
         wd_en = i[0];
         step();
         chk(1'b0, "R2");
      end
      wd_en = 1'b0;

      // R3: hold interval after supply rises
      pwr_ok = 1'b1;
      run_hold("R3");

      // R4: watchdog disabled, no expiry
      for (int i = 0; i < 3 * WIN; i++) begin
         step();
         chk(1'b1, "R4");
      end

      // R5: enable, no kicks, expiry on the WIN-th tick
      wd_en = 1'b1;
      run_window("R5");

      // R7: repeating pulse and window
      for (int r = 0; r < 2; r++) begin
         run_hold("R7");
         run_window("R7");
      end

      // R8: kicks during the pulse are ignored; the next window is full
      for (int i = 1; i <= HOLD; i++) begin
         kick = ~kick;
         step();
         chk(i == HOLD, "R8");
      end
      run_window("R8");
      run_hold("R8");

      // R6: kick after every possible tick count, both polarities alternate
      for (int g = 1; g < WIN; g++) begin
         for (int i = 0; i < g; i++) begin
            step();
            chk(1'b1, "R6");
         end
         kick = ~kick;
         run_window("R6");
         run_hold("R6");
      end

      // R10: kick edge lands with the expiring tick
      for (int i = 0; i < WIN - 1; i++) step();
      chk(1'b1, "R10");
      kick = ~kick;
      tick_aligned();
      chk(1'b1, "R10");
      run_window("R10");

      // R9: supply drop in mid-pulse
      step();
      step();
      chk(1'b0, "R9");
      pwr_ok = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         chk(1'b0, "R9");
      end
      pwr_ok = 1'b1;
      run_hold("R9");
      run_window("R9");
      run_hold("R9");

      // R13: synchronizer latency of a supply fall
      pwr_ok = 1'b0;
      repeat (SYNC) @(negedge clk);
      chk(1'b1, "R13");
      @(negedge clk);
      chk(1'b0, "R13");
      pwr_ok = 1'b1;

      // R11: supply drop lands with the final hold tick
      for (int i = 1; i < HOLD; i++) begin
         step();
         chk(1'b0, "R11");
      end
      pwr_ok = 1'b0;
      tick_aligned();
      chk(1'b0, "R11");
      repeat (4) @(negedge clk);
      pwr_ok = 1'b1;
      run_hold("R11");

      // R12: disable during a pulse, pulse completes, then no more pulses
      run_window("R12");
      wd_en = 1'b0;
      run_hold("R12");
      for (int i = 0; i < 2 * WIN; i++) begin
         step();
         chk(1'b1, "R12");
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule